// File: doc/BRIEF.md
# External bus request arbiter

This block hands a processor core's external memory port over to another bus master. The other master pulls an active-low request line. The arbiter answers with an active-low grant. At the same time it turns off the core's address, data and strobe drivers and holds the core frozen with a stall signal. When the request line goes high again, the grant drops, the drivers come back on and the stall clears. The core then carries on from the point where it stopped.

The grant never cuts into an external access that is already running, and that includes its wait states. The core's memory sequencer reports each access with a busy flag, and it marks the last cycle of the access with an end flag. If a request is pending when an access finishes, the grant starts in the next cycle. This is true even when the same instruction still has more external accesses to make, so the hand-off can land between two accesses of one instruction.

Arbitration goes on while reset is asserted and during boot. By default the request is treated as asynchronous: it is synchronized first, and the grant follows one cycle after the request is recognized. A legacy configuration input changes this. The request is then taken as a synchronous input, and the grant follows it within the same cycle.

Top module: `ext_bus_arb`

## Requirements
- R1: While an access is busy and has not reached its end cycle, the grant is deasserted and the drivers stay enabled. If a request has been recognized, the grant asserts in the cycle that follows the access's end cycle.
- R2: In normal mode, suppose the request is sampled low at clock edge n and no access is running. The grant reads low from edge n+2 onward. This is two synchronizer flops plus one state register.
- R3: A pending grant is issued between two accesses, in the cycle right after the first access ends. The grant does not wait for the instruction to complete.
- R4: Grant low, drive enable low and stall high always occur together. When no grant is active, drive enable is 1 and stall is 0.
- R5: In normal mode, suppose the request is sampled high at edge m while granted. From edge m+2 onward the grant reads high, the drivers are enabled and the stall is cleared.
- R6: While rst_ni is low, the busy and end flags are ignored and requests are still arbitrated with the R2 latency. With no request pending during reset, the outputs are grant high, drive enable 1 and stall 0.
- R7: With legacy_mode_i = 1, the request is used without synchronization. If no access is holding the bus, the grant follows the request line in the same cycle, both when it asserts and when it releases.
- R8: In legacy mode, a request made during a running access is granted in the cycle after the access's end cycle.
- R9: If the request is withdrawn while the block is still waiting for an access to finish, no grant is issued when the access ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low core reset; while low, the access flags are masked |
| bus_req_ni | input | 1 | Active-low bus request from the external master |
| legacy_mode_i | input | 1 | 1: synchronous request, grant in the same cycle |
| acc_busy_i | input | 1 | An external access occupies the port this cycle |
| acc_end_i | input | 1 | This cycle is the last one of the current access |
| bus_grant_no | output | 1 | Active-low bus grant |
| drv_en_o | output | 1 | Enable for the address, data and strobe drivers |
| core_stall_o | output | 1 | Freezes core execution |

## Verification
Three cases take careful timing at the ports. The first is a request that is recognized while an access is still counting down its wait states. The second is the same request withdrawn before the end cycle. The third is a request granted between two accesses of one instruction. The vector table lines up each request edge two cycles ahead of the busy and end flags, so that the synchronized request lands inside the access. It then checks that the grant appears exactly one cycle after the end flag, or never when the request was withdrawn. A directed sequence holds reset low with the busy flag high, which shows that the grant still arrives with normal latency.

// File: rtl/ext_bus_arb_pkg.sv
package ext_bus_arb_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_GRANT = 2'd2
  } arb_state_e;
endpackage

// File: rtl/ext_bus_req_sync.sv
// Free-running synchronizer, no reset: it must keep tracking through reset.
module ext_bus_req_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic req_ni,
  output logic req_o
);
  logic [STAGES-1:0] q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i) q[0] <= ~req_ni;
    end else begin : g_chain
      always_ff @(posedge clk_i) q <= {q[STAGES-2:0], ~req_ni};
    end
  endgenerate

  assign req_o = q[STAGES-1];
endmodule

// File: rtl/ext_bus_acc_track.sv
// Access still owns the port past this cycle; masked while the core is in reset.
module ext_bus_acc_track (
  input  logic rst_ni,
  input  logic acc_busy_i,
  input  logic acc_end_i,
  output logic hold_o
);
  assign hold_o = rst_ni & acc_busy_i & ~acc_end_i;
endmodule

// File: rtl/ext_bus_grant_fsm.sv
module ext_bus_grant_fsm
  import ext_bus_arb_pkg::*;
(
  input  logic clk_i,
  input  logic legacy_i,
  input  logic req_seen_i,
  input  logic acc_hold_i,
  output logic grant_o
);
  arb_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (req_seen_i) state_d = acc_hold_i ? ST_WAIT : ST_GRANT;
      ST_WAIT:  if (!req_seen_i) state_d = ST_IDLE;
                else if (!acc_hold_i) state_d = ST_GRANT;
      ST_GRANT: if (!req_seen_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  // Unreset on purpose: arbitration runs through reset and any stale
  // state clears within one cycle once the request is seen high.
  always_ff @(posedge clk_i) state_q <= state_d;

  // Legacy: grant follows the raw request combinationally.
  assign grant_o = ((state_q == ST_GRANT) && (!legacy_i || req_seen_i)) ||
                   (legacy_i && (state_q == ST_IDLE) && req_seen_i && !acc_hold_i);
endmodule

// File: rtl/ext_bus_arb.sv
module ext_bus_arb #(
  parameter int SYNC_STAGES = 2,
  parameter int MAX_HOLD    = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bus_req_ni,
  input  logic legacy_mode_i,
  input  logic acc_busy_i,
  input  logic acc_end_i,
  output logic bus_grant_no,
  output logic drv_en_o,
  output logic core_stall_o
);
  logic req_sync, req_seen, acc_hold, grant;

  ext_bus_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .req_ni (bus_req_ni),
    .req_o  (req_sync)
  );

  ext_bus_acc_track u_track (
    .rst_ni     (rst_ni),
    .acc_busy_i (acc_busy_i),
    .acc_end_i  (acc_end_i),
    .hold_o     (acc_hold)
  );

  assign req_seen = legacy_mode_i ? ~bus_req_ni : req_sync;

  ext_bus_grant_fsm u_fsm (
    .clk_i      (clk_i),
    .legacy_i   (legacy_mode_i),
    .req_seen_i (req_seen),
    .acc_hold_i (acc_hold),
    .grant_o    (grant)
  );

  assign bus_grant_no = ~grant;
  assign drv_en_o     = ~grant;
  assign core_stall_o = grant;
endmodule

// File: rtl/ext_bus_arb_chk.sv
module ext_bus_arb_chk #(
  parameter int SYNC_STAGES = 2,
  parameter int MAX_HOLD    = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic bus_req_ni,
  input logic legacy_mode_i,
  input logic acc_busy_i,
  input logic acc_end_i,
  input logic bus_grant_no,
  input logic drv_en_o,
  input logic core_stall_o
);
  localparam int LIMIT = MAX_HOLD + SYNC_STAGES + 2;
  localparam int CW    = $clog2(LIMIT + 2) + 1;

  logic [CW-1:0] wait_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wait_cnt <= '0;
    else if (!bus_req_ni && bus_grant_no && !legacy_mode_i) begin
      if (wait_cnt != {CW{1'b1}}) wait_cnt <= wait_cnt + 1'b1;
    end else wait_cnt <= '0;
  end

  // R1
  no_grant_in_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc_busy_i && !acc_end_i) |-> (bus_grant_no && drv_en_o));

  // R1
  hold_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wait_cnt <= CW'(LIMIT));

  // R4
  outputs_coherent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (drv_en_o == bus_grant_no) && (core_stall_o == !bus_grant_no));

  // R2
  grant_after_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(bus_grant_no) && !legacy_mode_i) |-> !$past(bus_req_ni, 2));

  // R7
  legacy_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (legacy_mode_i && bus_req_ni) |-> bus_grant_no);
endmodule

bind ext_bus_arb ext_bus_arb_chk #(
  .SYNC_STAGES (SYNC_STAGES),
  .MAX_HOLD    (MAX_HOLD)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .bus_req_ni    (bus_req_ni),
  .legacy_mode_i (legacy_mode_i),
  .acc_busy_i    (acc_busy_i),
  .acc_end_i     (acc_end_i),
  .bus_grant_no  (bus_grant_no),
  .drv_en_o      (drv_en_o),
  .core_stall_o  (core_stall_o)
);

// File: tb/ext_bus_arb_tb.sv
module ext_bus_arb_tb;
  logic clk = 1'b0;
  logic rst_ni, bus_req_ni, legacy_mode_i, acc_busy_i, acc_end_i;
  logic bus_grant_no, drv_en_o, core_stall_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ext_bus_arb u_dut (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .bus_req_ni    (bus_req_ni),
    .legacy_mode_i (legacy_mode_i),
    .acc_busy_i    (acc_busy_i),
    .acc_end_i     (acc_end_i),
    .bus_grant_no  (bus_grant_no),
    .drv_en_o      (drv_en_o),
    .core_stall_o  (core_stall_o)
  );

  // {legacy, req_n, busy, end, exp_grant_n, exp_stall, exp_drv_en, req_no}
  localparam int NV = 37;
  localparam logic [10:0] VEC [NV] = '{
    {7'b0100101, 4'd4},  // R4 idle
    {7'b0000101, 4'd2},  // R2 request sampled
    {7'b0000101, 4'd2},
    {7'b0000101, 4'd2},
    {7'b0000010, 4'd2},  // R2 granted two edges later
    {7'b0100010, 4'd5},  // R5 release sampled
    {7'b0100010, 4'd5},
    {7'b0100010, 4'd5},
    {7'b0100101, 4'd5},  // R5 released
    {7'b0010101, 4'd1},  // R1 access with wait states
    {7'b0010101, 4'd1},
    {7'b0010101, 4'd1},
    {7'b0010101, 4'd1},
    {7'b0011101, 4'd1},  // R1 end cycle
    {7'b0000010, 4'd3},  // R3 granted before next access
    {7'b0100010, 4'd3},
    {7'b0100010, 4'd3},
    {7'b0100010, 4'd3},
    {7'b0111101, 4'd3},  // R3 second access after release
    {7'b0010101, 4'd9},  // R9 request then withdraw
    {7'b0010101, 4'd9},
    {7'b0110101, 4'd9},
    {7'b0110101, 4'd9},
    {7'b0111101, 4'd9},
    {7'b0100101, 4'd9},
    {7'b0100101, 4'd9},
    {7'b1100101, 4'd7},  // R7 legacy idle
    {7'b1000010, 4'd7},  // R7 same-cycle grant
    {7'b1000010, 4'd7},
    {7'b1100101, 4'd7},  // R7 same-cycle release
    {7'b1100101, 4'd7},
    {7'b1010101, 4'd8},  // R8 legacy during access
    {7'b1011101, 4'd8},
    {7'b1000010, 4'd8},
    {7'b1100101, 4'd8},
    {7'b1100101, 4'd8},
    {7'b0100101, 4'd8}
  };

  task automatic check_out(input logic eg, input logic es, input logic ed,
                           input int rq, input string what);
    checks++;
    if (bus_grant_no !== eg || core_stall_o !== es || drv_en_o !== ed) begin
      errors++;
      $display("FAIL R%0d %s: got grant_n=%b stall=%b drv=%b expected grant_n=%b stall=%b drv=%b",
               rq, what, bus_grant_no, core_stall_o, drv_en_o, eg, es, ed);
    end
  endtask

  task automatic drive(input logic rs, input logic lg, input logic rq,
                       input logic bs, input logic en);
    @(negedge clk);
    rst_ni = rs; legacy_mode_i = lg; bus_req_ni = rq; acc_busy_i = bs; acc_end_i = en;
    #1;
  endtask

  initial begin
    rst_ni = 1'b0; legacy_mode_i = 1'b0; bus_req_ni = 1'b1;
    acc_busy_i = 1'b0; acc_end_i = 1'b0;
    repeat (4) drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    check_out(1'b1, 1'b0, 1'b1, 6, "R6 reset idle state");
    repeat (2) drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);

    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VEC[i][10], VEC[i][9], VEC[i][8], VEC[i][7]);
      check_out(VEC[i][6], VEC[i][5], VEC[i][4], int'(VEC[i][3:0]), $sformatf("vector %0d", i));
    end

    // R6: arbitration in reset, busy flag masked
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    check_out(1'b1, 1'b0, 1'b1, 6, "R6 reset request sampled");
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    check_out(1'b1, 1'b0, 1'b1, 6, "R6 reset before grant");
    drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    check_out(1'b0, 1'b1, 1'b0, 6, "R6 grant during reset");
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    check_out(1'b0, 1'b1, 1'b0, 6, "R6 held until release seen");
    drive(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    check_out(1'b1, 1'b0, 1'b1, 6, "R6 release during reset");
    drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    drive(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
    check_out(1'b1, 1'b0, 1'b1, 4, "R4 idle after reset exit");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule